// File: doc/BRIEF.md
# Keyed Reset and Power-Off Control Registers

This block holds three 32-bit words behind a small register bus: a reset-control word, a reset-status word and a watchdog word. A write changes state only when its top byte carries an 8-bit unlock key. When the key is missing, the write is thrown away and a sticky error flag is set. Software can clear that flag with a dedicated input. When the key is present, the key byte is zeroed before the word is stored.

An accepted write to the reset-control word with its trigger bit set produces a single-cycle request pulse. The low 12 bits of the reset-status word choose which request is sent. A magic code there asks the rest of the chip to power off. Any other value asks for a system reset. The block only issues the requests. Watchdog counting and the distribution of reset are left to the logic around it.

Reads are strobed and registered, so data arrives one cycle after the strobe. Only whole 32-bit words are addressed inside a 512-byte window. The `rst_n` input is asserted asynchronously, and its release must already be synchronous to `clk`.

Top module: `rstguard_regs`

## Requirements
- R1: After reset, the control word reads 0x00000102, the status word reads 0x00001000, the watchdog word reads 0, both request outputs are low and `key_err` is low.
- R2: A write is accepted only when `bus_wdata[31:24]` equals 0x5A. Any other key leaves all three words unchanged and produces no request pulse.
- R3: An accepted write stores `{8'h00, bus_wdata[23:0]}`, so bits [31:24] of every stored word always read as zero.
- R4: The words decode at byte offsets 0x1C (control), 0x20 (status) and 0x24 (watchdog). This includes non-word-aligned offsets such as 0x1D: a read of any other offset returns 0, and a write to any other offset changes nothing, even with a valid key.
- R5: An accepted write to the control word with bit 5 set raises a request for exactly one cycle. The request is visible in the same cycle in which the new control value becomes readable. A control write with bit 5 clear raises no request.
- R6: At the trigger, `shutdown_req` fires if bits [11:0] of the status word, as held before that write, equal 0x555. Otherwise `reset_req` fires.
- R7: Read data appears on `bus_rdata` in the cycle after `bus_rd` is sampled high, and holds in every cycle without a read. A read and a write in the same cycle return the value from before the write.
- R8: A write with a wrong key sets `key_err`, which stays set until `key_err_clr` is sampled high. A wrong-key write and a clear in the same cycle leave the flag set.
- R9: `reset_req` and `shutdown_req` are never high together, and both are low in every cycle that does not follow a trigger.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| bus_addr | input | 9 | Byte offset inside the 512-byte window |
| bus_wr | input | 1 | Write strobe |
| bus_wdata | input | 32 | Write data; bits [31:24] carry the unlock key |
| bus_rd | input | 1 | Read strobe |
| bus_rdata | output | 32 | Registered read data, valid the cycle after the strobe |
| key_err_clr | input | 1 | Clears the sticky key-error flag |
| key_err | output | 1 | Sticky flag: a wrong-key write was seen |
| reset_req | output | 1 | One-cycle system reset request |
| shutdown_req | output | 1 | One-cycle power-off request |

## Verification
Two pairs of functions can land in the same cycle.

The first pair is setting and clearing `key_err`. The bench drives a wrong-key write and `key_err_clr` on the same edge, and expects the flag to stay high. A lone clear afterwards must bring it low.

The second pair is a read and a write to the same word. The bench strobes `bus_rd` and `bus_wr` together on the watchdog word, and expects the old value on `bus_rdata`. A following read must return the new value.

The trigger path also depends on a value written in an earlier cycle. The status word is rewritten just before each trigger, and the chosen request is judged against that stored status value.

// File: rtl/rstguard_pkg.sv
package rstguard_pkg;

  localparam int DATA_W   = 32;
  localparam int ADDR_W   = 9;
  localparam int KEY_W    = 8;
  localparam int NUM_REGS = 3;
  localparam int MAGIC_W  = 12;
  localparam int TRIG_BIT = 5;

  localparam logic [KEY_W-1:0]   UNLOCK_KEY  = 8'h5A;
  localparam logic [MAGIC_W-1:0] OFF_MAGIC   = 12'h555;
  localparam logic [ADDR_W-1:0]  OFFS_CTRL   = 9'h01C;
  localparam logic [ADDR_W-1:0]  OFFS_STAT   = 9'h020;
  localparam logic [ADDR_W-1:0]  OFFS_WDOG   = 9'h024;

  typedef enum logic [1:0] {
    SEL_CTRL = 2'd0,
    SEL_STAT = 2'd1,
    SEL_WDOG = 2'd2,
    SEL_NONE = 2'd3
  } reg_sel_e;

  function automatic logic [DATA_W-1:0] reg_reset_value(input int idx);
    case (idx)
      0:       return 32'h0000_0102;
      1:       return 32'h0000_1000;
      default: return '0;
    endcase
  endfunction

endpackage

// File: rtl/rstguard_gate.sv
module rstguard_gate
  import rstguard_pkg::*;
#(
  parameter int                DW        = DATA_W,
  parameter int                AW        = ADDR_W,
  parameter int                KW        = KEY_W,
  parameter logic [KW-1:0]     KEY       = UNLOCK_KEY,
  parameter logic [AW-1:0]     A_CTRL    = OFFS_CTRL,
  parameter logic [AW-1:0]     A_STAT    = OFFS_STAT,
  parameter logic [AW-1:0]     A_WDOG    = OFFS_WDOG
) (
  input  logic          wr_en,
  input  logic [AW-1:0] addr,
  input  logic [DW-1:0] wdata,
  output logic          wr_ok,
  output logic          wr_bad,
  output reg_sel_e      sel,
  output logic [DW-1:0] payload
);

  localparam int BODY_W = DW - KW;

  logic key_match;

  always_comb begin
    key_match = (wdata[DW-1 -: KW] == KEY);
    wr_ok     = wr_en & key_match;
    wr_bad    = wr_en & ~key_match;
    payload   = {{KW{1'b0}}, wdata[BODY_W-1:0]};
  end

  always_comb begin
    if (addr == A_CTRL)      sel = SEL_CTRL;
    else if (addr == A_STAT) sel = SEL_STAT;
    else if (addr == A_WDOG) sel = SEL_WDOG;
    else                     sel = SEL_NONE;
  end

endmodule

// File: rtl/rstguard_bank.sv
module rstguard_bank
  import rstguard_pkg::*;
#(
  parameter int DW = DATA_W,
  parameter int KW = KEY_W,
  parameter int NR = NUM_REGS,
  parameter int MW = MAGIC_W
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_ok,
  input  reg_sel_e      sel,
  input  logic [DW-1:0] payload,
  input  logic          rd_en,
  output logic [MW-1:0] stat_low,
  output logic [DW-1:0] rdata
);

  logic [DW-1:0] regs_q [NR];
  logic [DW-1:0] regs_d [NR];
  logic [DW-1:0] rd_mux;
  logic [DW-1:0] rdata_d;
  logic [DW-1:0] rdata_q;

  for (genvar g = 0; g < NR; g++) begin : g_word
    localparam logic [1:0]    MY_SEL = 2'(g);
    localparam logic [DW-1:0] RST_V  = DW'(reg_reset_value(g));
    logic wen;

    always_comb begin
      wen       = wr_ok && (sel == MY_SEL);
      regs_d[g] = wen ? payload : regs_q[g];
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) regs_q[g] <= RST_V;
      else        regs_q[g] <= regs_d[g];
    end

    assert_write_needs_key_R2: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(regs_q[g]) |-> $past(wr_ok && (sel == MY_SEL)));

    assert_key_byte_zero_R3: assert property (@(posedge clk) disable iff (!rst_n)
      regs_q[g][DW-1 -: KW] == '0);
  end

  always_comb begin
    unique case (sel)
      SEL_CTRL: rd_mux = regs_q[0];
      SEL_STAT: rd_mux = regs_q[1];
      SEL_WDOG: rd_mux = regs_q[2];
      default:  rd_mux = '0;
    endcase
    rdata_d = rd_en ? rd_mux : rdata_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rdata_q <= '0;
    else        rdata_q <= rdata_d;
  end

  assign rdata    = rdata_q;
  assign stat_low = regs_q[1][MW-1:0];

  assert_rdata_holds_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(rd_en) |-> $stable(rdata_q));

endmodule

// File: rtl/rstguard_trigger.sv
module rstguard_trigger
  import rstguard_pkg::*;
#(
  parameter int              MW    = MAGIC_W,
  parameter logic [MW-1:0]   MAGIC = OFF_MAGIC
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_ok,
  input  logic          wr_bad,
  input  reg_sel_e      sel,
  input  logic          trig_bit,
  input  logic [MW-1:0] stat_low,
  input  logic          err_clr,
  output logic          reset_req,
  output logic          shutdown_req,
  output logic          key_err
);

  logic fire;
  logic magic_hit;
  logic rst_req_d, rst_req_q;
  logic sd_req_d,  sd_req_q;
  logic err_d,     err_q;

  always_comb begin
    fire      = wr_ok && (sel == SEL_CTRL) && trig_bit;
    magic_hit = (stat_low == MAGIC);
    rst_req_d = fire && !magic_hit;
    sd_req_d  = fire && magic_hit;
    if (wr_bad)       err_d = 1'b1;
    else if (err_clr) err_d = 1'b0;
    else              err_d = err_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_req_q <= 1'b0;
      sd_req_q  <= 1'b0;
      err_q     <= 1'b0;
    end else begin
      rst_req_q <= rst_req_d;
      sd_req_q  <= sd_req_d;
      err_q     <= err_d;
    end
  end

  assign reset_req    = rst_req_q;
  assign shutdown_req = sd_req_q;
  assign key_err      = err_q;

  assert_one_request_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !(rst_req_q && sd_req_q));

  assert_req_needs_key_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (rst_req_q || sd_req_q) |-> $past(wr_ok && sel == SEL_CTRL));

  assert_shutdown_magic_R6: assert property (@(posedge clk) disable iff (!rst_n)
    sd_req_q |-> ($past(stat_low) == MAGIC));

  assert_err_sticky_R8: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(err_q) && !$past(err_clr)) |-> err_q);

endmodule

// File: rtl/rstguard_regs.sv
module rstguard_regs
  import rstguard_pkg::*;
#(
  parameter int                  DW     = DATA_W,
  parameter int                  AW     = ADDR_W,
  parameter int                  KW     = KEY_W,
  parameter int                  MW     = MAGIC_W,
  parameter int                  TB     = TRIG_BIT,
  parameter logic [KW-1:0]       KEY    = UNLOCK_KEY,
  parameter logic [MW-1:0]       MAGIC  = OFF_MAGIC,
  parameter logic [AW-1:0]       A_CTRL = OFFS_CTRL,
  parameter logic [AW-1:0]       A_STAT = OFFS_STAT,
  parameter logic [AW-1:0]       A_WDOG = OFFS_WDOG
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [AW-1:0] bus_addr,
  input  logic          bus_wr,
  input  logic [DW-1:0] bus_wdata,
  input  logic          bus_rd,
  output logic [DW-1:0] bus_rdata,
  input  logic          key_err_clr,
  output logic          key_err,
  output logic          reset_req,
  output logic          shutdown_req
);

  logic          wr_ok;
  logic          wr_bad;
  reg_sel_e      sel;
  logic [DW-1:0] payload;
  logic [MW-1:0] stat_low;

  rstguard_gate #(
    .DW(DW), .AW(AW), .KW(KW), .KEY(KEY),
    .A_CTRL(A_CTRL), .A_STAT(A_STAT), .A_WDOG(A_WDOG)
  ) u_gate (
    .wr_en   (bus_wr),
    .addr    (bus_addr),
    .wdata   (bus_wdata),
    .wr_ok   (wr_ok),
    .wr_bad  (wr_bad),
    .sel     (sel),
    .payload (payload)
  );

  rstguard_bank #(
    .DW(DW), .KW(KW), .NR(NUM_REGS), .MW(MW)
  ) u_bank (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr_ok    (wr_ok),
    .sel      (sel),
    .payload  (payload),
    .rd_en    (bus_rd),
    .stat_low (stat_low),
    .rdata    (bus_rdata)
  );

  rstguard_trigger #(
    .MW(MW), .MAGIC(MAGIC)
  ) u_trig (
    .clk          (clk),
    .rst_n        (rst_n),
    .wr_ok        (wr_ok),
    .wr_bad       (wr_bad),
    .sel          (sel),
    .trig_bit     (payload[TB]),
    .stat_low     (stat_low),
    .err_clr      (key_err_clr),
    .reset_req    (reset_req),
    .shutdown_req (shutdown_req),
    .key_err      (key_err)
  );

endmodule

// File: tb/rstguard_regs_bench.sv
module rstguard_regs_bench;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [8:0]  bus_addr = '0;
  logic        bus_wr = 1'b0;
  logic [31:0] bus_wdata = '0;
  logic        bus_rd = 1'b0;
  logic [31:0] bus_rdata;
  logic        key_err_clr = 1'b0;
  logic        key_err;
  logic        reset_req;
  logic        shutdown_req;

  int tests  = 0;
  int fails  = 0;
  bit done   = 1'b0;

  localparam logic [8:0] A_CTRL = 9'h01C;
  localparam logic [8:0] A_STAT = 9'h020;
  localparam logic [8:0] A_WDOG = 9'h024;

  always #2.5 clk = ~clk;

  rstguard_regs u_rstguard_regs (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
    .bus_wdata(bus_wdata), .bus_rd(bus_rd), .bus_rdata(bus_rdata),
    .key_err_clr(key_err_clr), .key_err(key_err),
    .reset_req(reset_req), .shutdown_req(shutdown_req)
  );

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: got 0x%08h expected 0x%08h", tag, act, exp);
    end
  endtask

  task automatic wr_reg(input logic [8:0] a, input logic [31:0] d,
                        output logic rr, output logic sd);
    @(negedge clk);
    bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
    @(negedge clk);
    bus_wr = 1'b0;
    rr = reset_req; sd = shutdown_req;
  endtask

  task automatic rd_reg(input logic [8:0] a, output logic [31:0] d);
    @(negedge clk);
    bus_addr = a; bus_rd = 1'b1;
    @(negedge clk);
    bus_rd = 1'b0;
    d = bus_rdata;
  endtask

  task automatic pulses_low(input string tag);
    @(negedge clk);
    check({tag, " reset_req low next cycle"}, {31'b0, reset_req}, 32'd0);
    check({tag, " shutdown_req low next cycle"}, {31'b0, shutdown_req}, 32'd0);
  endtask

  task automatic t_reset_values;
    logic [31:0] d;
    check("R1 key_err after reset", {31'b0, key_err}, 32'd0);
    check("R1 reset_req after reset", {31'b0, reset_req}, 32'd0);
    check("R1 shutdown_req after reset", {31'b0, shutdown_req}, 32'd0);
    rd_reg(A_CTRL, d); check("R1 control reset value", d, 32'h0000_0102);
    rd_reg(A_STAT, d); check("R1 status reset value", d, 32'h0000_1000);
    rd_reg(A_WDOG, d); check("R1 watchdog reset value", d, 32'h0);
  endtask

  task automatic t_bad_key;
    logic rr, sd; logic [31:0] d;
    wr_reg(A_STAT, 32'h1200_0555, rr, sd);
    check("R8 key_err set by wrong key", {31'b0, key_err}, 32'd1);
    rd_reg(A_STAT, d); check("R2 status unchanged by wrong key", d, 32'h0000_1000);
    wr_reg(A_CTRL, 32'hA500_0020, rr, sd);
    check("R2 no reset pulse on wrong key", {31'b0, rr}, 32'd0);
    check("R2 no shutdown pulse on wrong key", {31'b0, sd}, 32'd0);
    rd_reg(A_CTRL, d); check("R2 control unchanged by wrong key", d, 32'h0000_0102);
  endtask

  task automatic t_err_clear;
    @(negedge clk); key_err_clr = 1'b1;
    @(negedge clk); key_err_clr = 1'b0;
    check("R8 clear drops key_err", {31'b0, key_err}, 32'd0);
    @(negedge clk);
    bus_addr = A_WDOG; bus_wdata = 32'h0000_0001; bus_wr = 1'b1; key_err_clr = 1'b1;
    @(negedge clk);
    bus_wr = 1'b0; key_err_clr = 1'b0;
    check("R8 wrong key wins over clear", {31'b0, key_err}, 32'd1);
    @(negedge clk); key_err_clr = 1'b1;
    @(negedge clk); key_err_clr = 1'b0;
    check("R8 clear after coincidence", {31'b0, key_err}, 32'd0);
  endtask

  task automatic t_key_strip;
    logic rr, sd; logic [31:0] d;
    wr_reg(A_WDOG, 32'h5AFF_FFFF, rr, sd);
    rd_reg(A_WDOG, d); check("R3 key byte zeroed in store", d, 32'h00FF_FFFF);
  endtask

  task automatic t_decode;
    logic rr, sd; logic [31:0] d;
    wr_reg(9'h028, 32'h5A00_0020, rr, sd);
    check("R4 no pulse on undecoded write", {31'b0, rr | sd}, 32'd0);
    wr_reg(9'h01D, 32'h5A00_0020, rr, sd);
    check("R4 no pulse on misaligned write", {31'b0, rr | sd}, 32'd0);
    rd_reg(A_CTRL, d); check("R4 control untouched by misaligned write", d, 32'h0000_0102);
    rd_reg(9'h028, d); check("R4 undecoded read returns zero", d, 32'h0);
    rd_reg(9'h1FC, d); check("R4 top-of-window read returns zero", d, 32'h0);
  endtask

  task automatic t_reset_request;
    logic rr, sd; logic [31:0] d;
    wr_reg(A_CTRL, 32'h5A00_00DF, rr, sd);
    check("R5 no pulse with trigger bit clear", {31'b0, rr | sd}, 32'd0);
    @(negedge clk);
    bus_addr = A_CTRL; bus_wdata = 32'h5A00_0020; bus_wr = 1'b1;
    @(negedge clk);
    bus_wr = 1'b0; bus_rd = 1'b1;
    check("R6 reset_req with plain status", {31'b0, reset_req}, 32'd1);
    check("R9 shutdown_req stays low", {31'b0, shutdown_req}, 32'd0);
    @(negedge clk);
    bus_rd = 1'b0;
    check("R5 reset_req one cycle", {31'b0, reset_req}, 32'd0);
    check("R5 new control value readable", bus_rdata, 32'h0000_0020);
  endtask

  task automatic t_shutdown;
    logic rr, sd;
    wr_reg(A_STAT, 32'h5A12_3555, rr, sd);
    check("R9 status write raises nothing", {31'b0, rr | sd}, 32'd0);
    wr_reg(A_CTRL, 32'h5A00_0021, rr, sd);
    check("R6 shutdown_req with magic status", {31'b0, sd}, 32'd1);
    check("R9 reset_req stays low on shutdown", {31'b0, rr}, 32'd0);
    pulses_low("R5 shutdown");
  endtask

  task automatic t_near_magic;
    logic rr, sd;
    wr_reg(A_STAT, 32'h5A00_0554, rr, sd);
    wr_reg(A_CTRL, 32'h5A00_0020, rr, sd);
    check("R6 near-magic status gives reset", {31'b0, rr}, 32'd1);
    check("R6 near-magic status no shutdown", {31'b0, sd}, 32'd0);
    pulses_low("R9 after near-magic");
  endtask

  task automatic t_read_during_write;
    logic rr, sd; logic [31:0] d;
    wr_reg(A_WDOG, 32'h5A00_1234, rr, sd);
    @(negedge clk);
    bus_addr = A_WDOG; bus_wdata = 32'h5A00_ABCD; bus_wr = 1'b1; bus_rd = 1'b1;
    @(negedge clk);
    bus_wr = 1'b0; bus_rd = 1'b0;
    check("R7 read with write sees old value", bus_rdata, 32'h0000_1234);
    repeat (3) @(negedge clk);
    check("R7 rdata holds without strobe", bus_rdata, 32'h0000_1234);
    rd_reg(A_WDOG, d); check("R7 later read sees new value", d, 32'h0000_ABCD);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset_values();
    t_bad_key();
    t_err_clear();
    t_key_strip();
    t_decode();
    t_reset_request();
    t_shutdown();
    t_near_magic();
    t_read_during_write();
    if (!done) begin
      done = 1'b1;
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      tests++; fails++;
      $display("FAIL watchdog: got 0x%08h expected 0x%08h", 32'd0, 32'd1);
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

endmodule